// File: doc/BRIEF.md
# Auxiliary ADC Serial Command and Readout Port

This block is the serial side of a slow auxiliary converter. A host writes 16-bit command frames over an active-low chip select, a serial clock and a data input. The block decodes a start bit and an output-enable bit from each frame. It asks an external converter model for a sample, captures the 10-bit answer, and returns that answer on the serial data output during a later frame.

The data output has two roles. While a conversion is under way with the output enabled, it is driven high as a busy flag. When the conversion ends it is driven low. At the next chip-select falling edge it starts carrying the stored result, most significant bit first. A host can chain frames with both bits set: each frame reads back the previous sample and launches the next one when chip select rises. High impedance is represented by a separate output-enable port.

All serial pins are sampled by the system clock. The serial clock must therefore run well below the system clock (half periods of at least four system clocks).

Top module: `aux_adc_spi`

## Requirements
- R1: DIN is shifted in MSB first on SCLK rising edges while chip select is low. A frame is acted on at the chip-select rising edge only if it had at least 16 clocks and its bits [15:11] equal ADDR (default 5'h13). Shorter frames and frames with another address start nothing.
- R2: An accepted frame with bit 0 (start) set while no conversion runs produces exactly one single-cycle conv_req pulse.
- R3: When a started frame also has bit 10 (enable) set, dout_oe is 1 and dout is 1 for as long as the conversion runs. With bit 10 clear, dout_oe stays 0.
- R4: A conv_done pulse during a conversion stores conv_data and ends the conversion. If the output is enabled, dout then reads 0.
- R5: At the first chip-select falling edge with the output enabled and no conversion running, a readout begins. dout shows D9 at once, advances one bit on each SCLK falling edge down to D0, and holds D0 for the remaining six clocks of the frame.
- R6: A frame with bits 10 and 0 both set reads out the previous result and, at its chip-select rise, starts the next conversion with dout driven high.
- R7: A readout frame that does not start a conversion leaves dout_oe at 0 after chip select rises.
- R8: A frame with bit 10 set and bit 0 clear starts no conversion, drives dout low, and lets the next frame read the stored result, including one from a conversion run with the output disabled.
- R9: A start command that arrives during a conversion produces no conv_req and sets overrun, which stays 1 until reset.
- R10: After reset, dout_oe, conv_req and overrun are 0.
- R11: A chip-select falling edge during a conversion starts no readout; dout stays high through that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial command data |
| dout | output | 1 | Serial busy flag / result data |
| dout_oe | output | 1 | 1 when dout is driven, 0 for high impedance |
| conv_req | output | 1 | One-cycle request to start a conversion |
| conv_done | input | 1 | One-cycle pulse when the conversion has finished |
| conv_data | input | 10 | Conversion result, valid with conv_done |
| overrun | output | 1 | Sticky flag: start command refused while busy |

## Verification
The hardest states to reach are those in which the host talks to the block while a conversion is still running. These are a readout attempted during a conversion and a start command refused while busy. With a short converter they never occur, because a single 16-bit frame outlasts the conversion. The bench therefore makes the latency of its counter-based converter model a variable. It raises that latency far above the length of a frame and then issues several frames in a row, so a chip-select fall and a second start command both land inside one conversion.

// File: rtl/aux_adc_spi.sv
module aux_adc_spi #(
  parameter int          DATA_W     = 10,
  parameter int          FRAME_BITS = 16,
  parameter int          ADDR_W     = 5,
  parameter logic [4:0]  ADDR       = 5'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic              conv_req,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              overrun
);
  localparam int RXC_W  = $clog2(FRAME_BITS + 1);
  localparam int TXC_W  = $clog2(DATA_W);
  localparam int EN_BIT = 10;
  localparam int ST_BIT = 0;

  typedef enum logic [1:0] {M_HIZ, M_BUSY, M_LOW, M_SHIFT} mode_t;

  logic [2:0] cs_q, sck_q, din_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= 3'b111;
      sck_q <= 3'b000;
      din_q <= 3'b000;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sclk};
      din_q <= {din_q[1:0], din};
    end

  wire cs_fall  = cs_q[2] & ~cs_q[1];
  wire cs_rise  = ~cs_q[2] & cs_q[1];
  wire cs_low   = ~cs_q[1];
  wire sck_rise = ~sck_q[2] & sck_q[1];
  wire sck_fall = sck_q[2] & ~sck_q[1];

  logic [FRAME_BITS-1:0] rx_sh;
  logic [RXC_W-1:0]      rx_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh  <= '0;
      rx_cnt <= '0;
    end else if (cs_fall) begin
      rx_cnt <= '0;
    end else if (cs_low && sck_rise) begin
      rx_sh <= {rx_sh[FRAME_BITS-2:0], din_q[1]};
      if (rx_cnt != RXC_W'(FRAME_BITS)) rx_cnt <= rx_cnt + 1'b1;
    end

  mode_t             mode;
  logic              oe_en, busy;
  logic [DATA_W-1:0] result, tx_sh;
  logic [TXC_W-1:0]  tx_cnt;

  wire frame_ok  = cs_rise && rx_cnt == RXC_W'(FRAME_BITS) &&
                   rx_sh[FRAME_BITS-1 -: ADDR_W] == ADDR;
  wire cmd_start = rx_sh[ST_BIT];
  wire cmd_en    = rx_sh[EN_BIT];
  wire start_ok  = frame_ok & cmd_start & ~busy;
  wire start_rej = frame_ok & cmd_start & busy;
  wire reading   = (mode == M_SHIFT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode     <= M_HIZ;
      oe_en    <= 1'b0;
      busy     <= 1'b0;
      result   <= '0;
      tx_sh    <= '0;
      tx_cnt   <= '0;
      conv_req <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      conv_req <= 1'b0;
      if (conv_done && busy) begin
        busy   <= 1'b0;
        result <= conv_data;
        if (mode == M_BUSY) mode <= M_LOW;
      end
      if (cs_fall && oe_en && !busy && !reading) begin
        mode   <= M_SHIFT;
        tx_sh  <= result;
        tx_cnt <= '0;
      end
      if (reading && cs_low && sck_fall && tx_cnt != TXC_W'(DATA_W-1)) begin
        tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
        tx_cnt <= tx_cnt + 1'b1;
      end
      if (start_rej) overrun <= 1'b1;
      if (start_ok) begin
        conv_req <= 1'b1;
        busy     <= 1'b1;
        oe_en    <= cmd_en;
        mode     <= cmd_en ? M_BUSY : M_HIZ;
      end else if (frame_ok && !cmd_start) begin
        if (reading) begin
          oe_en <= 1'b0;
          mode  <= M_HIZ;
        end else begin
          oe_en <= cmd_en;
          mode  <= !cmd_en ? M_HIZ : (busy ? M_BUSY : M_LOW);
        end
      end else if (cs_rise && reading && !frame_ok) begin
        oe_en <= 1'b0;
        mode  <= M_HIZ;
      end
    end

  assign dout    = (mode == M_BUSY) | (reading & tx_sh[DATA_W-1]);
  assign dout_oe = (mode != M_HIZ);

  assert_single_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);
  assert_busy_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_oe) |-> dout);
  assert_no_req_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && busy) |=> !conv_req);
  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(busy));
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_release_at_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_oe) |-> $past(cs_rise));
  assert_shift_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && $past(reading) && !$past(sck_fall) && !$past(cs_fall)) |-> $stable(dout));
endmodule

// File: tb/aux_adc_spi_test.sv
module aux_adc_spi_test;
  localparam logic [4:0] ADDR = 5'h13;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, din = 0;
  logic dout, dout_oe, conv_req, conv_done = 0, overrun;
  logic [9:0] model_val = '0;
  int lat = 50, cnt_left = 0, req_cnt = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  aux_adc_spi uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .conv_req(conv_req), .conv_done(conv_done),
    .conv_data(model_val), .overrun(overrun));

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (!rst_n) cnt_left <= 0;
    else if (conv_req) begin
      cnt_left <= lat;
      req_cnt  <= req_cnt + 1;
    end else if (cnt_left > 0) begin
      if (cnt_left == 1) conv_done <= 1'b1;
      cnt_left <= cnt_left - 1;
    end
  end

  function automatic logic [15:0] cmd(input logic en, input logic st, input logic [4:0] a = ADDR);
    return {a, en, 9'b0, st};
  endfunction

  function automatic logic [15:0] pat(input logic [9:0] v);
    return {v, {6{v[0]}}};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input int nclk, output logic [15:0] rx);
    rx = '0;
    cs_n = 0;
    idle(HALF);
    for (int i = 0; i < nclk; i++) begin
      din = w[15-i];
      idle(HALF);
      if (i < 16) rx[15-i] = dout;
      sclk = 1;
      idle(HALF);
      sclk = 0;
    end
    idle(HALF);
    cs_n = 1;
    idle(HALF);
  endtask

  task automatic t_reset;
    chk("R10 dout_oe", {15'b0, dout_oe}, 16'h0);
    chk("R10 conv_req", {15'b0, conv_req}, 16'h0);
    chk("R10 overrun", {15'b0, overrun}, 16'h0);
  endtask

  task automatic t_rejected_frames;
    logic [15:0] rx;
    int r0 = req_cnt;
    frame(cmd(1, 1), 12, rx);
    idle(20);
    chk("R1 short frame no req", 16'(req_cnt - r0), 16'h0);
    frame(cmd(1, 1, 5'h0C), 16, rx);
    idle(20);
    chk("R1 wrong address no req", 16'(req_cnt - r0), 16'h0);
    chk("R1 output stays off", {15'b0, dout_oe}, 16'h0);
  endtask

  task automatic t_disabled_then_read;
    logic [15:0] rx;
    int r0 = req_cnt;
    model_val = 10'h2A5;
    frame(cmd(0, 1), 16, rx);
    chk("R2 one request", 16'(req_cnt - r0), 16'h1);
    chk("R3 disabled during conversion", {15'b0, dout_oe}, 16'h0);
    idle(lat + 20);
    chk("R3 disabled after conversion", {15'b0, dout_oe}, 16'h0);
    frame(cmd(1, 0), 16, rx);
    chk("R8 no request", 16'(req_cnt - r0), 16'h1);
    chk("R8 driven low", {14'b0, dout_oe, dout}, 16'h2);
    frame(cmd(1, 0), 16, rx);
    chk("R5 readout of stored result", rx, pat(10'h2A5));
    chk("R7 released after readout", {15'b0, dout_oe}, 16'h0);
  endtask

  task automatic t_chain;
    logic [15:0] rx;
    model_val = 10'h3F0;
    frame(cmd(1, 1), 16, rx);
    chk("R3 busy flag high", {14'b0, dout_oe, dout}, 16'h3);
    idle(lat + 20);
    chk("R4 done drives low", {14'b0, dout_oe, dout}, 16'h2);
    model_val = 10'h155;
    frame(cmd(1, 1), 16, rx);
    chk("R6 reads previous result", rx, pat(10'h3F0));
    chk("R6 next conversion busy", {14'b0, dout_oe, dout}, 16'h3);
    idle(lat + 20);
    model_val = 10'h0C3;
    frame(cmd(1, 1), 16, rx);
    chk("R6 second chained read", rx, pat(10'h155));
    idle(lat + 20);
    frame(cmd(0, 0), 16, rx);
    chk("R5 final readout", rx, pat(10'h0C3));
    chk("R7 released after final readout", {15'b0, dout_oe}, 16'h0);
  endtask

  task automatic t_busy_collisions;
    logic [15:0] rx;
    int r0;
    lat = 1500;
    model_val = 10'h1E2;
    frame(cmd(1, 1), 16, rx);
    r0 = req_cnt;
    frame(cmd(1, 0), 16, rx);
    chk("R11 no readout while busy", rx, 16'hFFFF);
    chk("R11 still busy high", {14'b0, dout_oe, dout}, 16'h3);
    frame(cmd(1, 1), 16, rx);
    chk("R9 refused start", 16'(req_cnt - r0), 16'h0);
    chk("R9 overrun set", {15'b0, overrun}, 16'h1);
    idle(lat);
    chk("R9 overrun sticky", {15'b0, overrun}, 16'h1);
    chk("R4 done after long conversion", {14'b0, dout_oe, dout}, 16'h2);
    frame(cmd(0, 0), 16, rx);
    chk("R5 readout after long conversion", rx, pat(10'h1E2));
    lat = 50;
    rst_n = 0;
    idle(4);
    rst_n = 1;
    idle(4);
    chk("R10 overrun cleared by reset", {15'b0, overrun}, 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(5);
    t_reset();
    rst_n = 1;
    idle(5);
    t_reset();
    t_rejected_frames();
    t_disabled_then_read();
    t_chain();
    t_busy_collisions();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule